// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, one access at a time, whether a memory access may proceed. It holds a small table of protection windows. Each window has a start address, a size exponent, a three-bit permission code, a no-execute flag and an enable flag. For each access the block takes the address, the kind of access (read, write or instruction fetch) and whether the requester is privileged. It finds every enabled window that contains the address and picks the one with the highest index. That window's rules grant the access or raise a fault. The index of the deciding window is reported with the verdict.

Windows are always a power of two in size and are aligned to their size. A start address that is not aligned is not rejected: its low bits are cleared and the window moves down. A typical use is a small no-access guard window placed over the bottom of a larger read-write stack window. The guard gets the higher index, so an overflowing stack faults when it reaches the guard. The verdict is computed combinationally and registered, so it appears one cycle after the access is presented. The table is programmed through a single-cycle write port.

Top module: `prot_region_checker`

## Requirements
- R1: A window with size field s (5 bits) covers 2^(s+1) bytes. A field below 4 is treated as 4, so the smallest window is 32 bytes.
- R2: The effective start address is the programmed start with its low s+1 bits cleared. A misaligned start moves the window down and is not flagged.
- R3: An address hits a window when it lies at or above the effective start and strictly below the effective start plus the size. The top bound is exclusive.
- R4: When several enabled windows hit, the highest-numbered one decides the verdict and is reported on `res_region`. The order in which the windows were written has no effect.
- R5: The permission code is decoded as follows.
  - 000: no access at either level.
  - 001: privileged read-write, unprivileged none.
  - 010: privileged read-write, unprivileged read.
  - 011: read-write at both levels.
  - 101: privileged read, unprivileged none.
  - 110 and 111: read at both levels.
  - An instruction fetch needs read permission.
- R6: Permission code 100 is reserved. It faults every access that resolves to that window.
- R7: An instruction fetch (`acc_kind` = 2'b10) faults when the deciding window has its no-execute bit set, whatever the permission code allows. Kind 2'b00 is a read and kind 2'b01 is a write.
- R8: When no enabled window hits, `res_hit` is 0 and `res_region` is 0. A privileged access is then allowed and an unprivileged access faults.
- R9: Size field 31 (4 GB) hits every 32-bit address, including 0xFFFFFFFF.
- R10: The result of an access presented with `acc_valid` high appears on the outputs after the next rising clock edge, with `res_valid` high for exactly that cycle.
- R11: A table write takes effect from the cycle after the write. An access presented in the same cycle as the write sees the old contents. A window written with its enable bit clear never hits.
- R12: After reset every window is disabled and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | 3 | Index of the entry being written |
| cfg_base | input | 32 | Start address of the window |
| cfg_size | input | 5 | Size exponent field (bytes = 2^(field+1)) |
| cfg_perm | input | 3 | Permission code |
| cfg_xn | input | 1 | No-execute flag |
| cfg_en | input | 1 | Window enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 00 read, 01 write, 10 instruction fetch |
| acc_priv | input | 1 | 1 for a privileged requester |
| res_valid | output | 1 | Result for the access of the previous cycle |
| res_fault | output | 1 | Access denied |
| res_hit | output | 1 | Some enabled window contained the address |
| res_region | output | 3 | Index of the deciding window (0 when none hit) |

## Verification
The hardest situations to reach are overlap stacks, where three or more enabled windows contain the same address with different codes. Purely random start addresses in a 32-bit space almost never overlap. The stimulus therefore confines random start addresses and access addresses to an 8 KB area and draws sizes between the 32-byte minimum and 4 KB, which makes multi-window hits common. One window is reprogrammed every few accesses. Directed cases cover the remaining corners: the exact top-bound address, a misaligned start, the whole-space window, the reserved code, and a write that lands in the same cycle as an access.

// File: rtl/prot_pkg.sv
// Package: prot_pkg
// Shared types and permission decode for the protection region checker.
// Assumes 3-bit permission codes and a 5-bit size exponent field.
package prot_pkg;

    localparam int SIZE_W    = 5;
    localparam int PERM_W    = 3;
    localparam int MIN_SIZE  = 4;
    localparam logic [PERM_W-1:0] PERM_RSVD = 3'b100;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10
    } acc_kind_e;

    typedef struct packed {
        logic              en;
        logic              xn;
        logic [PERM_W-1:0] perm;
        logic [SIZE_W-1:0] size;
    } region_attr_t;

    // Read permission for a code at the given privilege level
    function automatic logic perm_read_ok(input logic [PERM_W-1:0] perm, input logic priv);
        case (perm)
            3'b001, 3'b101:         perm_read_ok = priv;
            3'b010, 3'b011,
            3'b110, 3'b111:         perm_read_ok = 1'b1;
            default:                perm_read_ok = 1'b0;
        endcase
    endfunction

    // Write permission for a code at the given privilege level
    function automatic logic perm_write_ok(input logic [PERM_W-1:0] perm, input logic priv);
        case (perm)
            3'b001, 3'b010:         perm_write_ok = priv;
            3'b011:                 perm_write_ok = 1'b1;
            default:                perm_write_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/prot_region_file.sv
// Module: prot_region_file
// Holds the start address and attributes of every protection window.
// One entry is written per cycle; entries reset to disabled.
// Assumes indices at or above NUM_REGIONS are ignored on write.
module prot_region_file
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [ADDR_W-1:0]                   wr_base,
    input  region_attr_t                        wr_attr,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_q,
    output region_attr_t [NUM_REGIONS-1:0]      attr_q
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
        // Store one table entry when its index is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                attr_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                base_q[g] <= wr_base;
                attr_q[g] <= wr_attr;
            end
        end

        // R11: a write lands in the entry on the following cycle
        p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_idx == IDX_W'(g))) |=> (attr_q[g] == $past(wr_attr)
                                                 && base_q[g] == $past(wr_base)))
            else $error("p_write_lands_r11 entry %0d", g);
    end

endmodule

// File: rtl/prot_region_match.sv
// Module: prot_region_match
// Decides whether one address falls inside one protection window.
// The window is aligned to its own size by masking, so a misaligned start
// slides down; the top bound is exclusive and no adder is needed, so a
// window spanning the whole address space cannot overflow.
module prot_region_match
    import prot_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int EXP_W  = $clog2(ADDR_W + 2)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  region_attr_t      attr,
    output logic              hit
);

    logic [EXP_W-1:0]  span_exp;
    logic [ADDR_W-1:0] keep_mask;

    // Clamp the size field and turn it into a byte-count exponent
    always_comb begin
        if (int'(attr.size) < MIN_SIZE) begin
            span_exp = EXP_W'(MIN_SIZE + 1);
        end else begin
            span_exp = EXP_W'(attr.size) + EXP_W'(1);
        end
    end

    // Keep only the address bits above the window offset
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            keep_mask[i] = (i >= int'(span_exp));
        end
    end

    // Compare the surviving bits of address and start
    always_comb begin
        hit = attr.en && (((addr ^ base) & keep_mask) == '0);
    end

    // R9: the largest size field covers every address
    always_comb begin
        if (attr.en && (attr.size == 5'd31) && (ADDR_W <= 32)) begin
            p_whole_space_r9: assert (hit) else $error("p_whole_space_r9");
        end
    end

    // R1: sizes at or under the minimum behave as 32-byte blocks
    always_comb begin
        if (attr.en && (int'(attr.size) <= MIN_SIZE)) begin
            p_min_block_r1: assert (hit == (addr[ADDR_W-1:5] == base[ADDR_W-1:5]))
                else $error("p_min_block_r1");
        end
    end

endmodule

// File: rtl/prot_priority.sv
// Module: prot_priority
// Picks the highest-numbered window among those that hit.
// Reports index 0 when nothing hits.
module prot_priority #(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hit_vec,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);

    // Scan upward so the last hit seen, the highest index, wins
    always_comb begin
        win_idx = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (hit_vec[r]) begin
                win_idx = IDX_W'(r);
            end
        end
    end

    // Flag any hit at all
    always_comb begin
        any_hit = |hit_vec;
    end

    // R4: the winner hits and nothing above it hits
    always_comb begin
        if (any_hit) begin
            p_highest_wins_r4: assert ((hit_vec >> win_idx) == NUM_REGIONS'(1))
                else $error("p_highest_wins_r4");
        end
    end

endmodule

// File: rtl/prot_verdict.sv
// Module: prot_verdict
// Turns the deciding window's attributes, the access kind and the
// privilege level into a fault decision. With no window hit, privileged
// requesters pass and unprivileged ones fault.
module prot_verdict
    import prot_pkg::*;
(
    input  logic         any_hit,
    input  region_attr_t attr,
    input  logic [1:0]   kind,
    input  logic         priv,
    output logic         fault
);

    logic is_fetch;
    logic is_write;

    // Classify the access; both upper-bit kinds count as fetches
    always_comb begin
        is_fetch = kind[1];
        is_write = !kind[1] && kind[0];
    end

    // Apply background map, reserved code, no-execute, then code table
    always_comb begin
        if (!any_hit) begin
            fault = !priv;
        end else if (attr.perm == PERM_RSVD) begin
            fault = 1'b1;
        end else if (is_fetch && attr.xn) begin
            fault = 1'b1;
        end else if (is_write) begin
            fault = !perm_write_ok(attr.perm, priv);
        end else begin
            fault = !perm_read_ok(attr.perm, priv);
        end
    end

    // R6, R7, R5: denial cases that no other rule may override
    always_comb begin
        if (any_hit && (attr.perm == PERM_RSVD)) begin
            p_reserved_r6: assert (fault) else $error("p_reserved_r6");
        end
        if (any_hit && attr.xn && is_fetch) begin
            p_no_exec_r7: assert (fault) else $error("p_no_exec_r7");
        end
        if (any_hit && (attr.perm == 3'b000)) begin
            p_no_access_r5: assert (fault) else $error("p_no_access_r5");
        end
    end

endmodule

// File: rtl/prot_region_checker.sv
// Module: prot_region_checker
// Top of the protection region checker: table, per-window match,
// priority pick and verdict, with the result registered for one cycle.
// Assumes accesses and table writes are synchronous to clk.
module prot_region_checker
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [4:0]        cfg_size,
    input  logic [2:0]        cfg_perm,
    input  logic              cfg_xn,
    input  logic              cfg_en,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_priv,
    output logic              res_valid,
    output logic              res_fault,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_region
);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
    region_attr_t [NUM_REGIONS-1:0]     attr_q;
    region_attr_t                       wr_attr;
    logic [NUM_REGIONS-1:0]             hit_vec;
    logic                               any_hit;
    logic [IDX_W-1:0]                   win_idx;
    region_attr_t                       win_attr;
    logic                               fault_c;

    // Pack the write-port fields into one attribute word
    always_comb begin
        wr_attr = '{en: cfg_en, xn: cfg_xn, perm: cfg_perm, size: cfg_size};
    end

    prot_region_file #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W),
        .IDX_W       (IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_base (cfg_base),
        .wr_attr (wr_attr),
        .base_q  (base_q),
        .attr_q  (attr_q)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        prot_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .addr (acc_addr),
            .base (base_q[g]),
            .attr (attr_q[g]),
            .hit  (hit_vec[g])
        );
    end

    prot_priority #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_pick (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    // Select the attributes of the deciding window
    always_comb begin
        win_attr = attr_q[win_idx];
    end

    prot_verdict u_verdict (
        .any_hit (any_hit),
        .attr    (win_attr),
        .kind    (acc_kind),
        .priv    (acc_priv),
        .fault   (fault_c)
    );

    // Register the verdict for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_fault  <= 1'b0;
            res_hit    <= 1'b0;
            res_region <= '0;
        end else begin
            res_valid  <= acc_valid;
            res_fault  <= acc_valid && fault_c;
            res_hit    <= acc_valid && any_hit;
            res_region <= acc_valid ? win_idx : '0;
        end
    end

    // R10: a presented access yields a result on the next cycle only
    p_result_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid)
        else $error("p_result_latency_r10");

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid)
        else $error("p_no_spurious_r10");

    // R8: background map follows the privilege of the access
    p_background_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_fault != $past(acc_priv)))
        else $error("p_background_r8");

    p_background_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_region == '0))
        else $error("p_background_idx_r8");

endmodule

// File: tb/prot_region_checker_test.sv
`timescale 1ns/1ps
module prot_region_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [4:0]  cfg_size = '0;
    logic [2:0]  cfg_perm = '0;
    logic        cfg_xn = 1'b0;
    logic        cfg_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0;
    logic        res_valid, res_fault, res_hit;
    logic [2:0]  res_region;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] m_base [8];
    logic [4:0]  m_size [8];
    logic [2:0]  m_perm [8];
    logic        m_xn   [8];
    logic        m_en   [8];

    always #2.5 clk = ~clk;

    prot_region_checker uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_perm(cfg_perm), .cfg_xn(cfg_xn), .cfg_en(cfg_en),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
        .res_valid(res_valid), .res_fault(res_fault), .res_hit(res_hit), .res_region(res_region)
    );

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Permission table from R5 / R6 / R7, written as capabilities per code
    function automatic logic allowed(input logic [2:0] perm, input logic xn,
                                     input logic [1:0] kind, input logic priv);
        logic pr, pw, ur, uw;
        {pr, pw, ur, uw} = 4'b0000;
        case (perm)
            3'b001: {pr, pw} = 2'b11;
            3'b010: {pr, pw, ur} = 3'b111;
            3'b011: {pr, pw, ur, uw} = 4'b1111;
            3'b101: pr = 1'b1;
            3'b110, 3'b111: {pr, ur} = 2'b11;
            default: ;
        endcase
        if (kind == 2'b01) return priv ? pw : uw;
        if (kind == 2'b10 && xn) return 1'b0;
        return priv ? pr : ur;
    endfunction

    // Reference prediction using 64-bit range arithmetic (R1-style sizes, R3 bounds)
    function automatic void predict(input logic [31:0] a, input logic [1:0] k, input logic p,
                                    output logic ef, output logic eh, output logic [2:0] ei);
        eh = 1'b0;
        ei = 3'd0;
        for (int r = 0; r < 8; r++) begin
            if (m_en[r]) begin
                int e;
                longint unsigned sz, lo, aa;
                e  = ((int'(m_size[r]) < 4) ? 4 : int'(m_size[r])) + 1;
                sz = 64'd1 << e;
                lo = {32'd0, m_base[r]} & ~(sz - 64'd1);
                aa = {32'd0, a};
                if (aa >= lo && aa < lo + sz) begin
                    eh = 1'b1;
                    ei = 3'(r);
                end
            end
        end
        if (!eh) ef = !p;
        else     ef = !allowed(m_perm[ei], m_xn[ei], k, p);
    endfunction

    task automatic check_res(input string req, input logic ef, input logic eh, input logic [2:0] ei);
        checks++;
        if (res_valid !== 1'b1 || res_fault !== ef || res_hit !== eh || res_region !== ei) begin
            errors++;
            $display("FAIL %s: actual v=%b f=%b h=%b idx=%0d expected v=1 f=%b h=%b idx=%0d",
                     req, res_valid, res_fault, res_hit, res_region, ef, eh, ei);
        end
    endtask

    task automatic set_region(input int idx, input logic [31:0] b, input logic [4:0] s,
                              input logic [2:0] pm, input logic x, input logic en);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = b; cfg_size = s;
        cfg_perm = pm; cfg_xn = x; cfg_en = en;
        m_base[idx] = b; m_size[idx] = s; m_perm[idx] = pm; m_xn[idx] = x; m_en[idx] = en;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic p, input string req);
        logic ef, eh;
        logic [2:0] ei;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
        predict(a, k, p, ef, eh, ei);
        @(negedge clk);
        acc_valid = 1'b0;
        check_res(req, ef, eh, ei);
    endtask

    // Directed probe with a hand-computed expectation as well as the model
    task automatic probe_exp(input logic [31:0] a, input logic [1:0] k, input logic p,
                             input logic ef, input logic eh, input logic [2:0] ei, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p;
        @(negedge clk);
        acc_valid = 1'b0;
        check_res(req, ef, eh, ei);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int r = 0; r < 8; r++) begin
            m_base[r] = '0; m_size[r] = '0; m_perm[r] = '0; m_xn[r] = 1'b0; m_en[r] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R12: outputs are zero while in reset
        checks++;
        if (res_valid !== 1'b0 || res_fault !== 1'b0 || res_hit !== 1'b0 || res_region !== 3'd0) begin
            errors++;
            $display("FAIL R12: actual v=%b f=%b h=%b idx=%0d expected all 0",
                     res_valid, res_fault, res_hit, res_region);
        end
        rst_n = 1'b1;

        // R12 / R8: empty table gives the background map
        probe_exp(32'h2000_0000, 2'b01, 1'b1, 1'b0, 1'b0, 3'd0, "R12 priv background");
        probe_exp(32'h2000_0000, 2'b00, 1'b0, 1'b1, 1'b0, 3'd0, "R12 unpriv background");

        // R10: result valid for one cycle only
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10: actual res_valid=%b expected 0", res_valid);
        end

        // Stack window 0 (1 KB RW, no-exec) with a 32-byte guard in window 1
        set_region(0, 32'h2000_0000, 5'd9, 3'b011, 1'b1, 1'b1);
        set_region(1, 32'h2000_0000, 5'd4, 3'b000, 1'b1, 1'b1);
        probe_exp(32'h2000_0004, 2'b01, 1'b0, 1'b1, 1'b1, 3'd1, "R4 guard wins");
        probe_exp(32'h2000_001F, 2'b00, 1'b1, 1'b1, 1'b1, 3'd1, "R4 guard top byte");
        probe_exp(32'h2000_0020, 2'b01, 1'b0, 1'b0, 1'b1, 3'd0, "R3 above guard");
        probe_exp(32'h2000_03FF, 2'b01, 1'b0, 1'b0, 1'b1, 3'd0, "R1 1KB last byte");
        probe_exp(32'h2000_0400, 2'b00, 1'b0, 1'b1, 1'b0, 3'd0, "R3 exclusive top unpriv");
        probe_exp(32'h2000_0400, 2'b00, 1'b1, 1'b0, 1'b0, 3'd0, "R8 exclusive top priv");
        probe_exp(32'h2000_0100, 2'b10, 1'b1, 1'b1, 1'b1, 3'd0, "R7 no-exec fetch");

        // R4: swapped numbering lets the broad window win
        set_region(0, 32'h2000_0000, 5'd4, 3'b000, 1'b1, 1'b1);
        set_region(1, 32'h2000_0000, 5'd9, 3'b011, 1'b1, 1'b1);
        probe_exp(32'h2000_0004, 2'b01, 1'b0, 1'b0, 1'b1, 3'd1, "R4 swapped numbering");

        // R2: misaligned 64-byte window slides down to 0x20000800
        set_region(2, 32'h2000_0810, 5'd5, 3'b011, 1'b0, 1'b1);
        probe_exp(32'h2000_0805, 2'b00, 1'b0, 1'b0, 1'b1, 3'd2, "R2 masked start hit");
        probe_exp(32'h2000_0845, 2'b00, 1'b0, 1'b1, 1'b0, 3'd0, "R2 intended range miss");
        probe_exp(32'h2000_0840, 2'b01, 1'b0, 1'b1, 1'b0, 3'd0, "R3 64B exclusive top");

        // R1: size field below 4 behaves as 32 bytes
        set_region(3, 32'h2000_0C00, 5'd1, 3'b011, 1'b0, 1'b1);
        probe_exp(32'h2000_0C1F, 2'b01, 1'b0, 1'b0, 1'b1, 3'd3, "R1 min size inside");
        probe_exp(32'h2000_0C20, 2'b01, 1'b0, 1'b1, 1'b0, 3'd0, "R1 min size outside");

        // R6: reserved code faults even a privileged read
        set_region(4, 32'h2000_1000, 5'd4, 3'b100, 1'b0, 1'b1);
        probe_exp(32'h2000_1008, 2'b00, 1'b1, 1'b1, 1'b1, 3'd4, "R6 reserved code");

        // R5: every code, both levels, read/write/fetch
        for (int pm = 0; pm < 8; pm++) begin
            set_region(4, 32'h2000_1000, 5'd4, 3'(pm), 1'b0, 1'b1);
            for (int pv = 0; pv < 2; pv++) begin
                for (int kd = 0; kd < 3; kd++) begin
                    probe(32'h2000_1010, 2'(kd), 1'(pv), "R5 code table");
                end
            end
        end

        // R9: whole address space window
        set_region(7, 32'h1234_5678, 5'd31, 3'b110, 1'b0, 1'b1);
        probe_exp(32'hFFFF_FFFF, 2'b00, 1'b0, 1'b0, 1'b1, 3'd7, "R9 top address");
        probe_exp(32'h0000_0000, 2'b01, 1'b1, 1'b1, 1'b1, 3'd7, "R9 bottom write");

        // R11: disabled window never hits
        set_region(7, 32'h1234_5678, 5'd31, 3'b110, 1'b0, 1'b0);
        probe_exp(32'hFFFF_FFFF, 2'b00, 1'b0, 1'b1, 1'b0, 3'd0, "R11 disabled window");

        // R11: write and access in the same cycle see the old table
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd6; cfg_base = 32'h3000_0000; cfg_size = 5'd4;
        cfg_perm = 3'b011; cfg_xn = 1'b0; cfg_en = 1'b1;
        acc_valid = 1'b1; acc_addr = 32'h3000_0000; acc_kind = 2'b00; acc_priv = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check_res("R11 same-cycle write old view", 1'b1, 1'b0, 3'd0);
        m_base[6] = 32'h3000_0000; m_size[6] = 5'd4; m_perm[6] = 3'b011; m_xn[6] = 1'b0; m_en[6] = 1'b1;
        probe_exp(32'h3000_0000, 2'b00, 1'b0, 1'b0, 1'b1, 3'd6, "R11 next-cycle new view");

        // Constrained random: windows and addresses packed into 8 KB for overlaps
        for (int n = 0; n < 600; n++) begin
            if (n % 6 == 0) begin
                set_region(int'($urandom_range(0, 7)),
                           32'h2000_0000 | ($urandom & 32'h0000_1FFF),
                           5'($urandom_range(2, 11)),
                           3'($urandom_range(0, 7)),
                           1'($urandom_range(0, 1)),
                           ($urandom_range(0, 7) != 0));
            end
            probe(32'h2000_0000 | ($urandom & 32'h0000_1FFF),
                  2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                  "R4/R5 random overlap");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule